// File: doc/BRIEF.md
# Phase-Tracking Transaction Barrier

This block holds one barrier object in registers and drives it through a small command port. A producer sets the object up with a participant count. Participants then signal arrivals, and some of them also announce asynchronous transfers that are still in flight. Those transfers later report completion on a separate drain port. A phase ends only when two things have both reached zero: the arrivals still owed and the transfer amount still outstanding. At that point the object flips its phase bit and reloads its pending count in the same cycle, so the next phase can start without a gap.

Consumers poll without blocking. They issue a test-wait command that names a phase by its parity bit, or by a token bit that an earlier arrive returned. The answer arrives one cycle later. A set of per-cause error flags reports illegal use: a bad initial count, a double invalidation, commands sent to an object that is not set up, drain underflow, and arrival overrun. Illegal commands leave the state untouched.

Top module: `barr_txn_barrier`

## Requirements
- R1: After reset the object is not set up and every output is 0. While the object is not set up, every command except init and the reserved code, and any drain request, is ignored and sets err_flags bit 2 one cycle later.
- R2: Init is accepted only when cmd_arg lies in 1 to 2^CNT_W-1. Any other value sets err_flags bit 0 and leaves the state unchanged.
- R3: An accepted init sets the phase to 0, loads both the expected and the pending arrival counts with cmd_arg, and clears the transaction count to 0.
- R4: An accepted arrive (code 2, count cmd_arg) or arrive-with-transactions (code 3) raises rsp_valid one cycle later. rsp_token then holds the phase bit as it was before the command.
- R5: An arrive whose count exceeds the pending count is rejected and sets err_flags bit 4. Arrive-with-transactions adds cmd_arg to the transaction count and counts as one arrival, and it is rejected the same way when the pending count is 0.
- R6: Arrive-without-completion (code 4) subtracts cmd_arg from the pending count only when cmd_arg is less than the pending count. Otherwise it is rejected and sets err_flags bit 4. It never completes a phase.
- R7: When the pending count and the transaction count are both 0 after a cycle's updates, the phase bit toggles and pending is reloaded from expected in that same cycle. phase_done pulses for one cycle one cycle later.
- R8: A drain request subtracts txd_amount from the transaction count, saturates at 0 and sets err_flags bit 3 on underflow. When a drain and an arrive-with-transactions fall in the same cycle, the subtraction is applied before the addition.
- R9: Test-wait (code 5) answers one cycle later with rsp_valid=1, rsp_token equal to the current phase, and rsp_done=1 exactly when cmd_par differs from the current phase.
- R10: Invalidate (code 6) takes a set-up object out of use. Invalidating an object that is already out of use sets err_flags bit 1.
- R11: Init (code 1) and invalidate take priority over a drain request in the same cycle, and that drain is dropped without a flag.
- R12: Code 0 is idle and code 7 is reserved. Both are ignored with no response and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | ARG_W | Count for init and arrives, transaction amount for arrive-with-transactions |
| cmd_par | input | 1 | Phase parity or token bit queried by test-wait |
| txd_valid | input | 1 | Drain request for completed transactions |
| txd_amount | input | ARG_W | Amount drained |
| rsp_valid | output | 1 | Response for an accepted arrive or test-wait |
| rsp_token | output | 1 | Phase bit before an arrive, or the current phase for a test-wait |
| rsp_done | output | 1 | Test-wait result |
| phase_done | output | 1 | One-cycle pulse after a phase completes |
| err_flags | output | 5 | Per-cause error pulses |

## Verification
A corrupted pending or transaction count does not show up directly. It appears one cycle after the faulty update: phase_done either pulses too early or fails to pulse on the last arrival or drain, and the next test-wait reports the wrong rsp_done. A stuck phase bit shows up in the token returned by the very next arrive. A broken not-set-up flag shows up as responses or flags on commands that should have been ignored. The vector sequence is arranged so that each such fault is visible within one or two commands of where it occurs.

// File: rtl/barr_pkg.sv
package barr_pkg;
   typedef enum logic [2:0] {
      OP_IDLE      = 3'd0,
      OP_INIT      = 3'd1,
      OP_ARRIVE    = 3'd2,
      OP_ARRIVE_TX = 3'd3,
      OP_ARRIVE_NC = 3'd4,
      OP_TEST      = 3'd5,
      OP_INVAL     = 3'd6,
      OP_RSVD      = 3'd7
   } barr_op_e;

   localparam int ERR_W       = 5;
   localparam int ERR_INITCNT = 0;
   localparam int ERR_REINVAL = 1;
   localparam int ERR_NOTSET  = 2;
   localparam int ERR_TXUNDER = 3;
   localparam int ERR_OVERRUN = 4;
endpackage

// File: rtl/barr_cmd_dec.sv
module barr_cmd_dec #(
   parameter int ARG_W = 32,
   parameter int CNT_W = 20
) (
   input  logic [2:0]       op,
   input  logic [ARG_W-1:0] arg,
   input  logic             txd_valid,
   input  logic             obj_valid,
   input  logic [CNT_W-1:0] pend_q,
   output logic             init_ok,
   output logic             init_bad,
   output logic             inval_ok,
   output logic             inval_bad,
   output logic             hold,
   output logic             arr_en,
   output logic [CNT_W-1:0] arr_cnt,
   output logic             tx_add_en,
   output logic             test_en,
   output logic             txd_en,
   output logic             notset_err,
   output logic             overrun_err
);
   import barr_pkg::*;

   localparam logic [ARG_W-1:0] MAX_CNT = {{(ARG_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

   logic [ARG_W-1:0] pend_ext;
   logic             is_init, is_inval, is_arr, is_arrtx, is_nc, is_test;
   logic             arr_fit, nc_fit, arrtx_fit, needs_obj;

   always_comb begin
      pend_ext  = {{(ARG_W-CNT_W){1'b0}}, pend_q};
      is_init   = (op == OP_INIT);
      is_inval  = (op == OP_INVAL);
      is_arr    = (op == OP_ARRIVE);
      is_arrtx  = (op == OP_ARRIVE_TX);
      is_nc     = (op == OP_ARRIVE_NC);
      is_test   = (op == OP_TEST);
      needs_obj = is_arr | is_arrtx | is_nc | is_test;

      arr_fit   = (arg <= pend_ext);
      nc_fit    = (arg <  pend_ext);
      arrtx_fit = (pend_q != '0);

      init_ok   = is_init & (arg != '0) & (arg <= MAX_CNT);
      init_bad  = is_init & ~init_ok;
      inval_ok  = is_inval & obj_valid;
      inval_bad = is_inval & ~obj_valid;
      hold      = is_init | is_inval;

      arr_en    = obj_valid & ((is_arr & arr_fit) | (is_nc & nc_fit) | (is_arrtx & arrtx_fit));
      arr_cnt   = is_arrtx ? CNT_W'(1) : arg[CNT_W-1:0];
      tx_add_en = obj_valid & is_arrtx & arrtx_fit;
      test_en   = obj_valid & is_test;
      txd_en    = obj_valid & txd_valid & ~hold;

      notset_err  = ~obj_valid & (needs_obj | (txd_valid & ~hold));
      overrun_err = obj_valid & ((is_arr & ~arr_fit) | (is_nc & ~nc_fit) | (is_arrtx & ~arrtx_fit));
   end
endmodule

// File: rtl/barr_tx_count.sv
module barr_tx_count #(
   parameter int TX_W    = 20,
   parameter int ARG_W   = 32,
   parameter bit SAT_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sub_en,
   input  logic [ARG_W-1:0] sub_amt,
   input  logic             add_en,
   input  logic [ARG_W-1:0] add_amt,
   output logic [TX_W-1:0]  tx_q,
   output logic [TX_W-1:0]  tx_nx,
   output logic             underflow
);
   localparam int SW = ((TX_W > ARG_W) ? TX_W : ARG_W) + 1;
   localparam logic [SW-1:0] TX_MAX = {{(SW-TX_W){1'b0}}, {TX_W{1'b1}}};

   logic [SW-1:0] cur_e, sub_e, add_e, mid, sum;

   always_comb begin
      cur_e     = SW'(tx_q);
      sub_e     = sub_en ? SW'(sub_amt) : '0;
      add_e     = add_en ? SW'(add_amt) : '0;
      underflow = sub_en & (sub_e > cur_e);
      mid       = underflow ? '0 : (cur_e - sub_e);
      sum       = mid + add_e;
   end

   if (SAT_ADD) begin : g_sat
      always_comb tx_nx = (sum > TX_MAX) ? TX_W'(TX_MAX) : TX_W'(sum);
   end else begin : g_wrap
      always_comb tx_nx = TX_W'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tx_q <= '0;
      else if (clr) tx_q <= '0;
      else          tx_q <= tx_nx;
   end
endmodule

// File: rtl/barr_arrive_track.sv
module barr_arrive_track #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             arr_en,
   input  logic [CNT_W-1:0] arr_cnt,
   input  logic             obj_valid,
   input  logic             hold,
   input  logic             tx_zero_nx,
   output logic             phase_q,
   output logic [CNT_W-1:0] pend_q,
   output logic [CNT_W-1:0] exp_q,
   output logic             complete
);
   logic [CNT_W-1:0] pend_sub;

   always_comb begin
      pend_sub = arr_en ? (pend_q - arr_cnt) : pend_q;
      complete = obj_valid & ~hold & (pend_sub == '0) & tx_zero_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         pend_q  <= '0;
         exp_q   <= '0;
      end else if (load) begin
         phase_q <= 1'b0;
         pend_q  <= load_cnt;
         exp_q   <= load_cnt;
      end else if (complete) begin
         phase_q <= ~phase_q;
         pend_q  <= exp_q;
      end else if (arr_en) begin
         pend_q  <= pend_sub;
      end
   end
endmodule

// File: rtl/barr_txn_barrier.sv
module barr_txn_barrier #(
   parameter int ARG_W   = 32,
   parameter int CNT_W   = 20,
   parameter int TX_W    = 20,
   parameter bit SAT_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd_op,
   input  logic [ARG_W-1:0] cmd_arg,
   input  logic             cmd_par,
   input  logic             txd_valid,
   input  logic [ARG_W-1:0] txd_amount,
   output logic             rsp_valid,
   output logic             rsp_token,
   output logic             rsp_done,
   output logic             phase_done,
   output logic [4:0]       err_flags
);
   import barr_pkg::*;

   if (ARG_W <= CNT_W) begin : g_bad_arg_w
      $error("ARG_W must exceed CNT_W so out-of-range init counts can be seen");
   end
   if (CNT_W < 1 || TX_W < 1) begin : g_bad_w
      $error("CNT_W and TX_W must be at least 1");
   end

   logic             obj_valid;
   logic             init_ok, init_bad, inval_ok, inval_bad, hold;
   logic             arr_en, tx_add_en, test_en, txd_en, notset_err, overrun_err;
   logic [CNT_W-1:0] arr_cnt, pend_q, exp_q;
   logic [TX_W-1:0]  tx_q, tx_nx;
   logic             underflow, phase_q, complete;
   logic [ERR_W-1:0] err_vec;

   barr_cmd_dec #(.ARG_W(ARG_W), .CNT_W(CNT_W)) u_dec (
      .op(cmd_op), .arg(cmd_arg), .txd_valid(txd_valid), .obj_valid(obj_valid),
      .pend_q(pend_q), .init_ok(init_ok), .init_bad(init_bad), .inval_ok(inval_ok),
      .inval_bad(inval_bad), .hold(hold), .arr_en(arr_en), .arr_cnt(arr_cnt),
      .tx_add_en(tx_add_en), .test_en(test_en), .txd_en(txd_en),
      .notset_err(notset_err), .overrun_err(overrun_err)
   );

   barr_tx_count #(.TX_W(TX_W), .ARG_W(ARG_W), .SAT_ADD(SAT_ADD)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(init_ok), .sub_en(txd_en), .sub_amt(txd_amount),
      .add_en(tx_add_en), .add_amt(cmd_arg), .tx_q(tx_q), .tx_nx(tx_nx),
      .underflow(underflow)
   );

   barr_arrive_track #(.CNT_W(CNT_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .load(init_ok), .load_cnt(cmd_arg[CNT_W-1:0]),
      .arr_en(arr_en), .arr_cnt(arr_cnt), .obj_valid(obj_valid), .hold(hold),
      .tx_zero_nx(tx_nx == '0), .phase_q(phase_q), .pend_q(pend_q), .exp_q(exp_q),
      .complete(complete)
   );

   always_comb begin
      err_vec              = '0;
      err_vec[ERR_INITCNT] = init_bad;
      err_vec[ERR_REINVAL] = inval_bad;
      err_vec[ERR_NOTSET]  = notset_err;
      err_vec[ERR_TXUNDER] = underflow;
      err_vec[ERR_OVERRUN] = overrun_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obj_valid  <= 1'b0;
         rsp_valid  <= 1'b0;
         rsp_token  <= 1'b0;
         rsp_done   <= 1'b0;
         phase_done <= 1'b0;
         err_flags  <= '0;
      end else begin
         if (init_ok)       obj_valid <= 1'b1;
         else if (inval_ok) obj_valid <= 1'b0;
         rsp_valid  <= arr_en | test_en;
         rsp_token  <= (arr_en | test_en) ? phase_q : 1'b0;
         rsp_done   <= test_en & (cmd_par != phase_q);
         phase_done <= complete;
         err_flags  <= err_vec;
      end
   end
endmodule

// File: rtl/barr_txn_barrier_chk.sv
module barr_txn_barrier_chk #(
   parameter int CNT_W = 20,
   parameter int TX_W  = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cmd_op,
   input logic             rsp_valid,
   input logic             rsp_token,
   input logic             phase_done,
   input logic             obj_valid,
   input logic             init_ok,
   input logic             phase_q,
   input logic [CNT_W-1:0] pend_q,
   input logic [CNT_W-1:0] exp_q,
   input logic [TX_W-1:0]  tx_q
);
   import barr_pkg::*;

   a_r3_init_loads: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_ok) |-> (phase_q == 1'b0 && tx_q == '0 && pend_q == exp_q));

   a_r7_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      obj_valid |-> (pend_q <= exp_q));

   a_r6_nc_no_complete: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_op) == 3'(OP_ARRIVE_NC)) |-> !phase_done);

   a_r4_token_prior_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(cmd_op) != 3'(OP_TEST)) |-> (rsp_token == $past(phase_q)));

   a_r7_done_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      phase_done |-> (phase_q != $past(phase_q)));

   a_r1_unset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(obj_valid) && $past(cmd_op) != 3'(OP_INIT))
         |-> ($stable(phase_q) && $stable(tx_q) && !phase_done && !rsp_valid));
endmodule

bind barr_txn_barrier barr_txn_barrier_chk #(.CNT_W(CNT_W), .TX_W(TX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .rsp_valid(rsp_valid),
   .rsp_token(rsp_token), .phase_done(phase_done), .obj_valid(obj_valid),
   .init_ok(init_ok), .phase_q(phase_q), .pend_q(pend_q), .exp_q(exp_q), .tx_q(tx_q)
);

// File: tb/barr_txn_barrier_bench.sv
module barr_txn_barrier_bench;
   typedef struct packed {
      logic [2:0]  op;
      logic [31:0] arg;
      logic        par;
      logic        txv;
      logic [31:0] txa;
      logic        ev;
      logic        et;
      logic        ed;
      logic [4:0]  ee;
      logic        ep;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 33;
   // fields: op, arg, par, txd_valid, txd_amount | rsp_valid, token, done, err, phase_done | req
   localparam vec_t TBL [NV] = '{
      '{3'd2, 32'd1,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h04, 1'b0, 4'd1 },  // R1 arrive unset
      '{3'd5, 32'd0,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h04, 1'b0, 4'd1 },  // R1 test unset
      '{3'd1, 32'd0,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h01, 1'b0, 4'd2 },  // R2 count 0
      '{3'd1, 32'd1048576, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h01, 1'b0, 4'd2 },  // R2 count too big
      '{3'd1, 32'd3,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 4'd3 },  // R3 init 3
      '{3'd5, 32'd0,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 4'd9 },  // R9 phase 0 open
      '{3'd2, 32'd1,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 4'd4 },  // R4 arrive
      '{3'd3, 32'd10,      1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 4'd5 },  // R5 arrive tx 10
      '{3'd2, 32'd1,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 4'd7 },  // R7 tx still owed
      '{3'd0, 32'd0,       1'b0, 1'b1, 32'd4, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 4'd8 },  // R8 drain 4
      '{3'd5, 32'd0,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 4'd9 },  // R9 still open
      '{3'd0, 32'd0,       1'b0, 1'b1, 32'd6, 1'b0, 1'b0, 1'b0, 5'h00, 1'b1, 4'd7 },  // R7 drain completes
      '{3'd5, 32'd0,       1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 4'd9 },  // R9 parity 0 done
      '{3'd5, 32'd0,       1'b1, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 5'h00, 1'b0, 4'd9 },  // R9 parity 1 open
      '{3'd4, 32'd2,       1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 5'h00, 1'b0, 4'd6 },  // R6 nc 2 of 3
      '{3'd4, 32'd1,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h10, 1'b0, 4'd6 },  // R6 nc would finish
      '{3'd2, 32'd1,       1'b0, 1'b1, 32'd5, 1'b1, 1'b1, 1'b0, 5'h08, 1'b1, 4'd8 },  // R8 underflow + R7
      '{3'd2, 32'd5,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h10, 1'b0, 4'd5 },  // R5 overrun
      '{3'd3, 32'd7,       1'b0, 1'b1, 32'd3, 1'b1, 1'b0, 1'b0, 5'h08, 1'b0, 4'd8 },  // R8 sub before add
      '{3'd2, 32'd2,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 4'd8 },  // R8 tx 7 remains
      '{3'd1, 32'd2,       1'b0, 1'b1, 32'd7, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 4'd11},  // R11 init beats drain
      '{3'd5, 32'd0,       1'b1, 1'b0, 32'd0, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 4'd9 },  // R9 parity 1
      '{3'd2, 32'd2,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 4'd3 },  // R3 tx cleared
      '{3'd6, 32'd0,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 4'd10},  // R10 invalidate
      '{3'd6, 32'd0,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h02, 1'b0, 4'd10},  // R10 twice
      '{3'd0, 32'd0,       1'b0, 1'b1, 32'd1, 1'b0, 1'b0, 1'b0, 5'h04, 1'b0, 4'd1 },  // R1 drain unset
      '{3'd1, 32'd1,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 4'd3 },  // R3 re-init
      '{3'd5, 32'd0,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 4'd3 },  // R3 phase 0
      '{3'd3, 32'd0,       1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 4'd5 },  // R5 implicit 1
      '{3'd7, 32'd5,       1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 4'd12},  // R12 reserved
      '{3'd1, 32'd1048575, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 5'h00, 1'b0, 4'd2 },  // R2 max count
      '{3'd2, 32'd1048575, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 4'd7 },  // R7 big arrive
      '{3'd2, 32'd1,       1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 5'h00, 1'b0, 4'd4 }   // R4 after reload
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [31:0] cmd_arg = '0;
   logic        cmd_par = 1'b0;
   logic        txd_valid = 1'b0;
   logic [31:0] txd_amount = '0;
   logic        rsp_valid, rsp_token, rsp_done, phase_done;
   logic [4:0]  err_flags;
   int          checks = 0;
   int          errors = 0;

   always #4 clk = ~clk;

   barr_txn_barrier u_barr_txn_barrier (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_par(cmd_par),
      .txd_valid(txd_valid), .txd_amount(txd_amount), .rsp_valid(rsp_valid),
      .rsp_token(rsp_token), .rsp_done(rsp_done), .phase_done(phase_done),
      .err_flags(err_flags)
   );

   task automatic check_out(input string tag, input logic ev, input logic et,
                            input logic ed, input logic [4:0] ee, input logic ep);
      logic [8:0] act, exp;
      act = {rsp_valid, rsp_token, rsp_done, err_flags, phase_done};
      exp = {ev, et, ed, ee, ep};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: {rsp_valid,token,done,err,phase_done} actual %b expected %b",
                  tag, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] op, input logic [31:0] arg, input logic par,
                       input logic tv, input logic [31:0] ta);
      cmd_op = op; cmd_arg = arg; cmd_par = par; txd_valid = tv; txd_amount = ta;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_out("R1 reset outputs", 0, 0, 0, 5'h00, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 idle after reset", 0, 0, 0, 5'h00, 0);

      for (int i = 0; i < NV; i++) begin
         step(TBL[i].op, TBL[i].arg, TBL[i].par, TBL[i].txv, TBL[i].txa);
         check_out($sformatf("R%0d vector %0d", TBL[i].rq, i),
                   TBL[i].ev, TBL[i].et, TBL[i].ed, TBL[i].ee, TBL[i].ep);
      end
      step(3'd0, 0, 0, 0, 0);

      // R1: reset in the middle of a phase returns the object to unset
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R1 reset mid-phase", 0, 0, 0, 5'h00, 0);
      rst_n = 1'b1;
      step(3'd5, 0, 1'b1, 0, 0);
      check_out("R1 test after reset", 0, 0, 0, 5'h04, 0);
      // R2: bad init on a set-up object leaves it unchanged
      step(3'd1, 32'd2, 0, 0, 0);
      check_out("R3 init 2", 0, 0, 0, 5'h00, 0);
      step(3'd1, 32'd0, 0, 0, 0);
      check_out("R2 bad init while set", 0, 0, 0, 5'h01, 0);
      step(3'd2, 32'd1, 0, 0, 0);
      check_out("R2 pending kept at 2", 1, 0, 0, 5'h00, 0);
      // R11: invalidate beats a drain in the same cycle
      step(3'd6, 0, 0, 1'b1, 32'd9);
      check_out("R11 inval beats drain", 0, 0, 0, 5'h00, 0);
      step(3'd0, 0, 0, 0, 0);
      check_out("R12 idle", 0, 0, 0, 5'h00, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule